// File: doc/BRIEF.md
# SDR SDRAM Read Data Output Pipeline

This block is a device-side model of the data path of a single-data-rate SDRAM. Each clock it takes one decoded command (read, write, burst stop, precharge or no-op), a chip-select, a clock enable, a bank, a column, the address bit that selects auto-precharge or all-bank precharge, and one data-mask bit per byte lane. It produces the per-lane output enable, the column index and the data of every read word, each in the correct cycle for the configured CAS latency and burst length. It also produces the per-lane write strobe and column of every write word, and a one-cycle pulse when an auto-precharge starts.

Read words are scheduled through a latency pipeline. A later read, a burst stop or a precharge that covers the bank being read cuts the running burst off exactly CAS latency cycles after that command. A write flushes every pending read word at once. The data mask acts on read words two cycles late and on write words in the same cycle. A low clock enable freezes the whole block for the following edge. The data itself comes from a fixed function of the column index, because the storage array is not modelled.

Top module: `sdr_rd_datapath`

## Requirements
- R1: After reset, dq_oe, dq_out, wr_strb and ap_go are all zero, and the block acts as if the clock enable had been high at the last edge.
- R2: A READ (op 1) sampled at enabled edge n outputs burst word k (0 <= k < BL) during the cycle after enabled edge n+CL+k, with dq_oe all ones when DQM was low. dq_oe is zero in any cycle with no scheduled read word.
- R3: With order_ilv low, the low log2(BL) bits of word k's column are (start + k) mod BL. With order_ilv high, they are start XOR k. The upper column bits equal those of the start column in both orders.
- R4: Byte lane b of dq_out equals (rd_col mod 256) XOR 16*b when dq_oe[b] is high, and zero otherwise.
- R5: A READ sampled at enabled edge m during a burst ends the earlier burst after edge m+CL-1. The new burst's first word follows edge m+CL.
- R6: A burst stop (op 3) at enabled edge m, or a PRECHARGE (op 4) at edge m whose bank equals the bank of the most recent READ or whose a10 is high, leaves no read word from edge m+CL onward.
- R7: A PRECHARGE with a10 low to a bank other than the most recently read one has no effect on the read output.
- R8: A high dqm[b] at enabled edge m clears dq_oe[b] for the read word shown after enabled edge m+2.
- R9: A WRITE (op 2) sampled at enabled edge n writes word k during the cycle before enabled edge n+k. In that cycle wr_col carries word k's column, ordered as in R3, and wr_strb is the inverse of the dqm present in that same cycle. A READ or burst stop ends the write burst in the cycle it is presented. A WRITE clears every pending read word from the cycle after its edge.
- R10: cke low at one edge makes the next edge ignored. That edge executes no command and changes no burst, latency or mask state, wr_strb is zero in that cycle and ap_go is low after it. cke itself is sampled at every edge.
- R11: While cs_n is high, the cycle acts as op 0 whatever op shows.
- R12: A READ with a10 high at enabled edge n starts its precharge (ap_go high with ap_bank = that READ's bank, for the one cycle after the starting edge). It starts at the first later enabled edge that presents a READ, a WRITE, a burst stop or a PRECHARGE covering that bank, or otherwise at enabled edge n+BL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, acts one edge later |
| cs_n | input | 1 | Chip select, active low |
| op | input | 3 | Decoded command: 0 no-op, 1 read, 2 write, 3 burst stop, 4 precharge |
| bank | input | BANKW | Bank of the command |
| col | input | COLW | Start column of a read or write |
| a10 | input | 1 | Auto-precharge on read, all banks on precharge |
| dqm | input | BYTES | Per-byte data mask |
| order_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| dq_oe | output | BYTES | Per-byte read output enable |
| dq_out | output | 8*BYTES | Read data word |
| rd_col | output | COLW | Column of the read word now shown |
| wr_strb | output | BYTES | Per-byte write strobe for the current cycle |
| wr_col | output | COLW | Column of the write word in the current cycle |
| ap_go | output | 1 | Auto-precharge start pulse |
| ap_bank | output | BANKW | Bank of the auto-precharge |

## Verification
The bench builds the block with CAS latency 3, burst length 8, two byte lanes and a 9-bit column. The latency of 3 reproduces the case where a command two cycles after a read lands between the first burst's second word and the interrupting burst's start. The burst of 8 lets a start column in mid-block show the full wrap in both orders, and gives write and auto-precharge bursts enough beats to be cut short. Two lanes show that masking acts per byte and that the two-cycle read mask delay is counted only on enabled edges.

// File: rtl/sdr_rdp_pkg.sv
package sdr_rdp_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_BTERM = 3'd3,
    OP_PRE   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_READ = 2'd1,
    PK_STOP = 2'd2
  } pk_e;

  // column of burst word k; lb = log2 of the burst length
  function automatic logic [15:0] burst_addr(input logic [15:0] base, input logic [15:0] k,
                                             input int lb, input logic ilv);
    logic [15:0] m;
    logic [15:0] low;
    m   = (16'd1 << lb) - 16'd1;
    low = ilv ? (base ^ k) : (base + k);
    return (base & ~m) | (low & m);
  endfunction

  // stand-in data source: one byte per lane derived from the column
  function automatic logic [7:0] lane_byte(input logic [15:0] idx, input int b);
    return idx[7:0] ^ 8'(b << 4);
  endfunction

endpackage

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe
  import sdr_rdp_pkg::*;
#(
  parameter int CL    = 3,
  parameter int COLW  = 9,
  parameter int BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             flush,
  input  pk_e              kind_in,
  input  logic [COLW-1:0]  col_in,
  input  logic [BYTES-1:0] dqm_in,
  output pk_e              kind_out,
  output logic [COLW-1:0]  col_out,
  output logic [BYTES-1:0] mask_out
);
  localparam int RD_MASK_LAT = 2;
  localparam int MSTG        = RD_MASK_LAT + 1;

  for (genvar s = 0; s < CL; s++) begin : g_stage
    pk_e             k_q, k_d, k_src;
    logic [COLW-1:0] c_q, c_d, c_src;

    if (s == 0) begin : g_head
      assign k_src = kind_in;
      assign c_src = col_in;
    end else begin : g_link
      assign k_src = g_stage[s-1].k_q;
      assign c_src = g_stage[s-1].c_q;
    end

    always_comb begin
      k_d = k_q;
      c_d = c_q;
      if (en) begin
        k_d = flush ? PK_NONE : k_src;
        c_d = c_src;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        k_q <= PK_NONE;
        c_q <= '0;
      end else begin
        k_q <= k_d;
        c_q <= c_d;
      end
    end
  end

  assign kind_out = g_stage[CL-1].k_q;
  assign col_out  = g_stage[CL-1].c_q;

  logic [BYTES-1:0] m_q [MSTG];
  logic [BYTES-1:0] m_d [MSTG];

  always_comb begin
    for (int i = 0; i < MSTG; i++) m_d[i] = m_q[i];
    if (en) begin
      m_d[0] = dqm_in;
      for (int i = 1; i < MSTG; i++) m_d[i] = m_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MSTG; i++) m_q[i] <= '0;
    end else begin
      for (int i = 0; i < MSTG; i++) m_q[i] <= m_d[i];
    end
  end

  assign mask_out = m_q[MSTG-1];

endmodule

// File: rtl/sdr_rd_burst.sv
module sdr_rd_burst
  import sdr_rdp_pkg::*;
#(
  parameter int COLW  = 9,
  parameter int BL    = 4,
  parameter int BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             flush,
  input  logic             ilv,
  input  pk_e              kind_in,
  input  logic [COLW-1:0]  col_in,
  input  logic [BYTES-1:0] mask_in,
  output logic [BYTES-1:0] oe,
  output logic [COLW-1:0]  col_out
);
  localparam int LB = $clog2(BL);
  localparam int CW = (BL > 1) ? $clog2(BL) : 1;

  logic            act_q, act_d;
  logic [COLW-1:0] base_q, base_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (en) begin
      if (flush) begin
        act_d = 1'b0;
      end else if (kind_in == PK_READ) begin
        act_d  = 1'b1;
        base_d = col_in;
        cnt_d  = '0;
      end else if (kind_in == PK_STOP) begin
        act_d = 1'b0;
      end else if (act_q) begin
        if (cnt_q == CW'(BL - 1)) act_d = 1'b0;
        else                      cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign col_out = COLW'(burst_addr(16'(base_q), 16'(cnt_q), LB, ilv));
  assign oe      = act_q ? ~mask_in : '0;

  // R2
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !flush && kind_in == PK_READ |=> act_q && cnt_q == '0);
  // R6
  rd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !flush && kind_in == PK_STOP |=> !act_q);
  // R9
  rd_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && flush |=> !act_q);
  // R10
  rd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(act_q) && $stable(cnt_q) && $stable(base_q));

endmodule

// File: rtl/sdr_wr_beat.sv
module sdr_wr_beat
  import sdr_rdp_pkg::*;
#(
  parameter int COLW  = 9,
  parameter int BL    = 4,
  parameter int BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             is_wr,
  input  logic             is_rd,
  input  logic             is_bt,
  input  logic             ilv,
  input  logic [COLW-1:0]  col_in,
  input  logic [BYTES-1:0] dqm,
  output logic [BYTES-1:0] strb,
  output logic [COLW-1:0]  wcol
);
  localparam int LB = $clog2(BL);
  localparam int CW = (BL > 1) ? $clog2(BL) : 1;

  logic            wact_q, wact_d;
  logic [COLW-1:0] wbase_q, wbase_d;
  logic [CW-1:0]   wcnt_q, wcnt_d;
  logic            cont;

  assign cont = en & wact_q & ~is_rd & ~is_bt;
  assign strb = (is_wr | cont) ? ~dqm : '0;
  assign wcol = is_wr ? col_in : COLW'(burst_addr(16'(wbase_q), 16'(wcnt_q), LB, ilv));

  always_comb begin
    wact_d  = wact_q;
    wbase_d = wbase_q;
    wcnt_d  = wcnt_q;
    if (en) begin
      if (is_wr) begin
        wact_d  = (BL > 1);
        wbase_d = col_in;
        wcnt_d  = CW'(1);
      end else if (is_rd || is_bt) begin
        wact_d = 1'b0;
      end else if (wact_q) begin
        if (wcnt_q == CW'(BL - 1)) wact_d = 1'b0;
        else                       wcnt_d = wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact_q  <= 1'b0;
      wbase_q <= '0;
      wcnt_q  <= '0;
    end else begin
      wact_q  <= wact_d;
      wbase_q <= wbase_d;
      wcnt_q  <= wcnt_d;
    end
  end

  // R9
  wr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_bt) |=> !wact_q);
  // R10
  wr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(wact_q) && $stable(wcnt_q));

endmodule

// File: rtl/sdr_autopre.sv
module sdr_autopre #(
  parameter int BANKW = 2,
  parameter int BL    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             is_rd,
  input  logic             is_wr,
  input  logic             is_bt,
  input  logic             is_pre,
  input  logic             a10,
  input  logic [BANKW-1:0] bank,
  output logic             ap_go,
  output logic [BANKW-1:0] ap_bank
);
  localparam int CW = (BL > 1) ? $clog2(BL) : 1;

  logic             pend_q, pend_d;
  logic [BANKW-1:0] pb_q, pb_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             fire;
  logic [BANKW-1:0] apb_d;

  assign fire = en & pend_q & ((cnt_q == '0) | is_rd | is_wr | is_bt |
                               (is_pre & (a10 | (bank == pb_q))));

  always_comb begin
    pend_d = pend_q;
    pb_d   = pb_q;
    cnt_d  = cnt_q;
    apb_d  = fire ? pb_q : ap_bank;
    if (en) begin
      if (fire)        pend_d = 1'b0;
      else if (pend_q) cnt_d  = cnt_q - 1'b1;
      if (is_rd && a10) begin
        pend_d = 1'b1;
        pb_d   = bank;
        cnt_d  = CW'(BL - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pb_q    <= '0;
      cnt_q   <= '0;
      ap_go   <= 1'b0;
      ap_bank <= '0;
    end else begin
      pend_q  <= pend_d;
      pb_q    <= pb_d;
      cnt_q   <= cnt_d;
      ap_go   <= fire;
      ap_bank <= apb_d;
    end
  end

  // R12
  ap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_go |-> $past(pend_q));

endmodule

// File: rtl/sdr_rd_datapath.sv
module sdr_rd_datapath
  import sdr_rdp_pkg::*;
#(
  parameter int BYTES = 2,
  parameter int COLW  = 9,
  parameter int BANKW = 2,
  parameter int CL    = 3,
  parameter int BL    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cke,
  input  logic               cs_n,
  input  logic [2:0]         op,
  input  logic [BANKW-1:0]   bank,
  input  logic [COLW-1:0]    col,
  input  logic               a10,
  input  logic [BYTES-1:0]   dqm,
  input  logic               order_ilv,
  output logic [BYTES-1:0]   dq_oe,
  output logic [8*BYTES-1:0] dq_out,
  output logic [COLW-1:0]    rd_col,
  output logic [BYTES-1:0]   wr_strb,
  output logic [COLW-1:0]    wr_col,
  output logic               ap_go,
  output logic [BANKW-1:0]   ap_bank
);
  logic             cke_q;
  logic             en, live;
  logic             is_rd, is_wr, is_bt, is_pre, is_stop;
  logic [BANKW-1:0] rbank_q, rbank_d;
  pk_e              entry, pipe_kind;
  logic [COLW-1:0]  pipe_col;
  logic [BYTES-1:0] pipe_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign en      = cke_q;
  assign live    = en & ~cs_n;
  assign is_rd   = live & (op == OP_READ);
  assign is_wr   = live & (op == OP_WRITE);
  assign is_bt   = live & (op == OP_BTERM);
  assign is_pre  = live & (op == OP_PRE);
  assign is_stop = is_bt | (is_pre & (a10 | (bank == rbank_q)));
  assign entry   = is_rd ? PK_READ : (is_stop ? PK_STOP : PK_NONE);
  assign rbank_d = is_rd ? bank : rbank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbank_q <= '0;
    else        rbank_q <= rbank_d;
  end

  sdr_lat_pipe #(.CL(CL), .COLW(COLW), .BYTES(BYTES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en), .flush(is_wr),
    .kind_in(entry), .col_in(col), .dqm_in(dqm),
    .kind_out(pipe_kind), .col_out(pipe_col), .mask_out(pipe_mask)
  );

  sdr_rd_burst #(.COLW(COLW), .BL(BL), .BYTES(BYTES)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(en), .flush(is_wr), .ilv(order_ilv),
    .kind_in(pipe_kind), .col_in(pipe_col), .mask_in(pipe_mask),
    .oe(dq_oe), .col_out(rd_col)
  );

  sdr_wr_beat #(.COLW(COLW), .BL(BL), .BYTES(BYTES)) u_wr (
    .clk(clk), .rst_n(rst_n), .en(en), .is_wr(is_wr), .is_rd(is_rd),
    .is_bt(is_bt), .ilv(order_ilv), .col_in(col), .dqm(dqm),
    .strb(wr_strb), .wcol(wr_col)
  );

  sdr_autopre #(.BANKW(BANKW), .BL(BL)) u_ap (
    .clk(clk), .rst_n(rst_n), .en(en), .is_rd(is_rd), .is_wr(is_wr),
    .is_bt(is_bt), .is_pre(is_pre), .a10(a10), .bank(bank),
    .ap_go(ap_go), .ap_bank(ap_bank)
  );

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dq_out[8*b +: 8] = dq_oe[b] ? lane_byte(16'(rd_col), b) : 8'h00;
  end

endmodule

// File: tb/sim_sdr_rd_datapath.sv
module sim_sdr_rd_datapath;
  localparam int BYTES = 2, COLW = 9, BANKW = 2, CL = 3, BL = 8, NS = 8192;

  logic               clk, rst_n, cke, cs_n, a10, order_ilv;
  logic [2:0]         op;
  logic [BANKW-1:0]   bank;
  logic [COLW-1:0]    col;
  logic [BYTES-1:0]   dqm;
  logic [BYTES-1:0]   dq_oe, wr_strb;
  logic [8*BYTES-1:0] dq_out;
  logic [COLW-1:0]    rd_col, wr_col;
  logic               ap_go;
  logic [BANKW-1:0]   ap_bank;

  sdr_rd_datapath #(.BYTES(BYTES), .COLW(COLW), .BANKW(BANKW), .CL(CL), .BL(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .op(op), .bank(bank),
    .col(col), .a10(a10), .dqm(dqm), .order_ilv(order_ilv),
    .dq_oe(dq_oe), .dq_out(dq_out), .rd_col(rd_col), .wr_strb(wr_strb),
    .wr_col(wr_col), .ap_go(ap_go), .ap_bank(ap_bank)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  string tag = "R1";

  // reference state
  int  E, rbank, dcol, wbase, wk, pbank, pdue, ap_bk;
  bit  cke_m, dv, wact, pend, exp_ap;
  bit  sv [NS];
  int  sc [NS];
  bit [BYTES-1:0] dh [NS];
  bit [BYTES-1:0] dmask;

  function automatic int baddr(int base, int k, bit ilv);
    int m, low;
    m   = BL - 1;
    low = ilv ? (base ^ k) : (base + k);
    return ((base & ~m) | (low & m)) & ((1 << COLW) - 1);
  endfunction

  function automatic int lane_exp(int c, int b);
    return ((c & 255) ^ (b * 16)) & 255;
  endfunction

  task automatic chk(string t, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h at %0t", t, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit en, lv, rd, wr, bt, pr, fire;
    int n;
    if (!rst_n) begin
      E = 0; cke_m = 1; dv = 0; dcol = 0; dmask = '0; rbank = 0;
      wact = 0; wbase = 0; wk = 0; pend = 0; pbank = 0; pdue = 0;
      exp_ap = 0; ap_bk = 0;
      for (int i = 0; i < NS; i++) begin sv[i] = 0; sc[i] = 0; dh[i] = '0; end
    end else begin
      en = cke_m;
      exp_ap = 0;
      if (en) begin
        n  = E;
        lv = !cs_n;
        rd = lv && op == 3'd1;
        wr = lv && op == 3'd2;
        bt = lv && op == 3'd3;
        pr = lv && op == 3'd4;
        dh[n] = dqm;
        fire = pend && (n == pdue || rd || wr || bt || (pr && (a10 || int'(bank) == pbank)));
        if (fire) begin exp_ap = 1; ap_bk = pbank; pend = 0; end
        if (rd && a10) begin pend = 1; pbank = int'(bank); pdue = n + BL; end
        if (wr) for (int i = n; i <= n + CL + BL; i++) sv[i] = 0;
        if (rd || bt || (pr && (a10 || int'(bank) == rbank)))
          for (int i = n + CL; i <= n + CL + BL; i++) sv[i] = 0;
        if (rd) begin
          for (int k = 0; k < BL; k++) begin
            sv[n + CL + k] = 1;
            sc[n + CL + k] = baddr(int'(col), k, order_ilv);
          end
          rbank = int'(bank);
        end
        dv    = sv[n];
        dcol  = sc[n];
        dmask = (n >= 2) ? dh[n - 2] : '0;
        if (wr) begin wact = (BL > 1); wbase = int'(col); wk = 1; end
        else if (rd || bt) wact = 0;
        else if (wact) begin
          if (wk == BL - 1) wact = 0; else wk++;
        end
        E++;
      end
      cke_m = cke;
    end
  end

  always @(negedge clk) begin
    bit [BYTES-1:0] eoe, estb;
    logic [8*BYTES-1:0] edat;
    bit lv, cur, cont;
    int wc;
    if (rst_n) begin
      eoe = dv ? ~dmask : '0;
      chk(tag, "dq_oe", 32'(dq_oe), 32'(eoe));
      if (dv) chk("R3", "rd_col", 32'(rd_col), 32'(dcol));
      for (int b = 0; b < BYTES; b++)
        edat[8*b +: 8] = eoe[b] ? 8'(lane_exp(dcol, b)) : 8'h00;
      chk("R4", "dq_out", 32'(dq_out), 32'(edat));
      lv   = cke_m && !cs_n;
      cur  = lv && op == 3'd2;
      cont = cke_m && wact && !(lv && (op == 3'd1 || op == 3'd3));
      estb = (cur || cont) ? ~dqm : '0;
      wc   = cur ? int'(col) : baddr(wbase, wk, order_ilv);
      chk("R9", "wr_strb", 32'(wr_strb), 32'(estb));
      if (estb != '0) chk("R9", "wr_col", 32'(wr_col), 32'(wc));
      chk("R12", "ap_go", 32'(ap_go), 32'(exp_ap));
      if (exp_ap) chk("R12", "ap_bank", 32'(ap_bank), 32'(ap_bk));
    end
  end

  task automatic drv(int o, int bk, int c, bit a, bit [BYTES-1:0] m, bit ck, bit cs);
    op = 3'(o); bank = BANKW'(bk); col = COLW'(c); a10 = a; dqm = m; cke = ck; cs_n = cs;
    @(posedge clk); #2;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) drv(0, 0, 0, 0, '0, 1, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(64'd8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; order_ilv = 0;
    op = 0; bank = 0; col = 0; a10 = 0; dqm = '0; cke = 1; cs_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tag = "R1"; idle(3);

    tag = "R5";  // read at 0, read at 2 with CL 3
    drv(1, 0, 8, 0, '0, 1, 0); idle(1); drv(1, 0, 40, 0, '0, 1, 0); idle(14);

    tag = "R6";
    drv(1, 1, 16, 0, '0, 1, 0); idle(1); drv(3, 0, 0, 0, '0, 1, 0); idle(8);
    drv(1, 1, 24, 0, '0, 1, 0); idle(1); drv(4, 1, 0, 0, '0, 1, 0); idle(8);
    drv(1, 2, 32, 0, '0, 1, 0); drv(4, 0, 0, 1, '0, 1, 0); idle(10);

    tag = "R7";
    drv(1, 2, 48, 0, '0, 1, 0); idle(1); drv(4, 0, 0, 0, '0, 1, 0); idle(12);

    tag = "R8";
    drv(1, 0, 64, 0, '0, 1, 0); idle(2);
    drv(0, 0, 0, 0, 2'b01, 1, 0); drv(0, 0, 0, 0, 2'b10, 1, 0);
    drv(0, 0, 0, 0, 2'b11, 1, 0); idle(10);

    tag = "R10";
    drv(1, 3, 80, 0, '0, 1, 0); idle(4);
    drv(0, 0, 0, 0, '0, 0, 0); drv(1, 3, 200, 0, 2'b11, 0, 0);
    drv(3, 0, 0, 0, 2'b11, 1, 0); idle(12);

    tag = "R11";
    drv(1, 0, 96, 0, '0, 1, 0); idle(1); drv(3, 0, 0, 0, '0, 1, 1);
    drv(2, 0, 7, 0, '0, 1, 1); idle(12);

    tag = "R3"; order_ilv = 1;
    drv(1, 0, 5, 0, '0, 1, 0); idle(12);
    drv(1, 0, 133, 0, '0, 1, 0); idle(12);
    order_ilv = 0;
    drv(1, 0, 5, 0, '0, 1, 0); idle(12);

    tag = "R9";
    drv(2, 0, 3, 0, 2'b00, 1, 0); drv(0, 0, 0, 0, 2'b10, 1, 0);
    drv(0, 0, 0, 0, 2'b01, 1, 0); idle(8);
    drv(2, 0, 20, 0, '0, 1, 0); idle(2); drv(1, 0, 50, 0, '0, 1, 0); idle(12);
    drv(1, 0, 60, 0, '0, 1, 0); idle(4); drv(2, 0, 9, 0, 2'b11, 1, 0); idle(12);

    tag = "R12";
    drv(1, 2, 70, 1, '0, 1, 0); idle(12);
    drv(1, 1, 72, 1, '0, 1, 0); idle(2); drv(3, 0, 0, 0, '0, 1, 0); idle(12);

    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      int r, o;
      if (i == 2000) begin idle(20); order_ilv = 1; end
      r = int'($urandom % 16);
      o = (r < 6) ? 0 : (r < 9) ? 1 : (r < 11) ? 2 : (r < 12) ? 3 : (r < 14) ? 4 : 0;
      drv(o, int'($urandom % 4), int'($urandom % 512), ($urandom % 4) == 0,
          (($urandom % 5) == 0) ? BYTES'($urandom) : '0,
          ($urandom % 10) != 0, ($urandom % 12) == 0);
    end
    idle(20);
    summary();
  end

endmodule